// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Unit

This unit performs an unsigned 8-bit by 8-bit multiply or an unsigned 8-bit by 8-bit divide. It works on an accumulator operand and a second operand register. A single-cycle `start` request latches both operands and the operation select. The unit then spends a fixed number of cycles in an iterative datapath.

Multiplication is shift-and-add. Division is restoring shift-and-subtract. Each busy cycle resolves two operand bits, so an 8-bit operation takes four cycles. The latency is the same for every operand value.

When the operation completes, the result registers change and `done` pulses for one cycle. The result is split across the two result bytes, and the carry and overflow flags are written. The result registers keep their values until the next operation completes. A request that arrives while an operation is in flight is dropped.

Top module: `muldiv_seq`

## Requirements
- R1: A multiply (opDiv=0) returns the low byte of the 16-bit unsigned product on accOut and the high byte on bOut.
- R2: A multiply sets ovOut when the product high byte is non-zero (product above 255), and clears it otherwise.
- R3: A divide (opDiv=1) with a non-zero divisor returns the unsigned quotient accIn/bIn on accOut and the remainder on bOut.
- R4: A divide with a non-zero divisor clears ovOut.
- R5: A divide by zero sets ovOut and leaves the results equal to the latched operands: accOut = accIn and bOut = 0.
- R6: carryOut is 0 after every completed operation of either kind.
- R7: If start is sampled at clock edge k while the unit is idle, done is high only in the cycle after edge k+4, is low for the four cycles before it, and is a single-cycle pulse.
- R8: A start request during the four busy cycles is ignored. It neither changes the result of the operation in flight nor produces an extra done pulse.
- R9: After reset, accOut, bOut, carryOut, ovOut and done are all 0. The result outputs change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation (taken only when idle) |
| opDiv | input | 1 | Operation select: 0 multiply, 1 divide |
| accIn | input | 8 | Accumulator operand (multiplicand or dividend) |
| bIn | input | 8 | Second operand (multiplier or divisor) |
| accOut | output | 8 | Product low byte or quotient |
| bOut | output | 8 | Product high byte or remainder |
| carryOut | output | 1 | Carry flag, cleared by every operation |
| ovOut | output | 1 | Overflow flag (product above 255, or divisor zero) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random operand pairs drawn from a fixed seed drive both operations, and each result is compared against a product or quotient/remainder computed in the bench.

Directed cases separate the flag boundaries:
- 15×17 = 255 leaves overflow clear.
- 16×16 = 256 sets it.
- 255×255 fills both result bytes.
- A zero multiplicand is also exercised.

For divide:
- A zero divisor shows the held-operand behaviour.
- A divisor of one gives the full dividend as quotient.
- Equal operands give quotient one.
- A dividend smaller than the divisor gives quotient zero.

Every operation checks done low for four cycles and high on the fifth. One operation carries a second start during its busy window, which must leave its result and done pulse unchanged.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // latch operands and operation
    logic step;    // advance the iterative datapath
    logic finish;  // last step: publish results and flags
  } ctrl_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t strobe,
  output logic  isBusy,
  output logic  done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load   = start && !isBusy;
    strobe.step   = isBusy;
    strobe.finish = isBusy && (stepCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isBusy  <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        isBusy  <= 1'b1;
        stepCnt <= '0;
      end else if (strobe.finish) begin
        isBusy  <= 1'b0;
      end else if (isBusy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BITS_PER_STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            strobe,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] bOut,
  output logic             carryOut,
  output logic             ovOut
);
  localparam int WW = 2 * WIDTH;

  // work register: upper half holds partial product / remainder,
  // lower half holds remaining multiplier bits / quotient bits
  logic [WW-1:0]    work;
  logic [WIDTH-1:0] operand;
  logic [WIDTH-1:0] origAcc;
  logic             divMode;

  function automatic logic [WW-1:0] mulBit(input logic [WW-1:0] w,
                                           input logic [WIDTH-1:0] m);
    logic [WIDTH:0] sum;
    sum = {1'b0, w[WW-1:WIDTH]} + (w[0] ? {1'b0, m} : '0);
    return {sum, w[WIDTH-1:1]};
  endfunction

  function automatic logic [WW-1:0] divBit(input logic [WW-1:0] w,
                                           input logic [WIDTH-1:0] d);
    logic [WW:0]    sh;
    logic [WIDTH:0] top;
    logic [WIDTH:0] diff;
    sh   = {w, 1'b0};
    top  = sh[WW:WIDTH];
    diff = top - {1'b0, d};
    if (top >= {1'b0, d}) return {diff[WIDTH-1:0], sh[WIDTH-1:1], 1'b1};
    else                  return {top[WIDTH-1:0], sh[WIDTH-1:1], 1'b0};
  endfunction

  // chain of BITS_PER_STEP single-bit stages evaluated in one cycle
  logic [WW-1:0] chain [BITS_PER_STEP+1];
  assign chain[0] = work;

  for (genvar g = 0; g < BITS_PER_STEP; g++) begin : g_stage
    assign chain[g+1] = divMode ? divBit(chain[g], operand)
                                : mulBit(chain[g], operand);
  end

  logic [WW-1:0] nextWork;
  assign nextWork = chain[BITS_PER_STEP];

  logic divZero;
  assign divZero = divMode && (operand == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      work     <= '0;
      operand  <= '0;
      origAcc  <= '0;
      divMode  <= 1'b0;
      accOut   <= '0;
      bOut     <= '0;
      carryOut <= 1'b0;
      ovOut    <= 1'b0;
    end else begin
      if (strobe.load) begin
        work    <= {{WIDTH{1'b0}}, accIn};
        operand <= bIn;
        origAcc <= accIn;
        divMode <= opDiv;
      end else if (strobe.step) begin
        work <= nextWork;
      end

      if (strobe.finish) begin
        carryOut <= 1'b0;
        if (divZero) begin
          accOut <= origAcc;
          bOut   <= operand;
          ovOut  <= 1'b1;
        end else begin
          accOut <= nextWork[WIDTH-1:0];
          bOut   <= nextWork[WW-1:WIDTH];
          ovOut  <= divMode ? 1'b0 : (nextWork[WW-1:WIDTH] != '0);
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BITS_PER_STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] bOut,
  output logic             carryOut,
  output logic             ovOut,
  output logic             done
);
  localparam int STEPS = WIDTH / BITS_PER_STEP;

  ctrl_t strobe;
  logic  isBusy;

  muldiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .isBusy (isBusy),
    .done   (done)
  );

  muldiv_dp #(.WIDTH(WIDTH), .BITS_PER_STEP(BITS_PER_STEP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opDiv    (opDiv),
    .accIn    (accIn),
    .bIn      (bIn),
    .accOut   (accOut),
    .bOut     (bOut),
    .carryOut (carryOut),
    .ovOut    (ovOut)
  );
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int WIDTH = 8,
  parameter int STEPS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             opDiv,
  input logic [WIDTH-1:0] accIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] accOut,
  input logic [WIDTH-1:0] bOut,
  input logic             carryOut,
  input logic             ovOut,
  input logic             done,
  input logic             isBusy
);
  localparam int WW = 2 * WIDTH;

  logic [WIDTH-1:0] capA, capB;
  logic             capDiv;
  logic [7:0]       busyCycles;
  logic             accepted;

  assign accepted = start && !isBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capA <= '0; capB <= '0; capDiv <= 1'b0; busyCycles <= '0;
    end else if (accepted) begin
      capA <= accIn; capB <= bIn; capDiv <= opDiv; busyCycles <= '0;
    end else if (isBusy && busyCycles != 8'hFF) begin
      busyCycles <= busyCycles + 1'b1;
    end
  end

  logic [WW-1:0] prodChk, recomb;
  assign prodChk = {{WIDTH{1'b0}}, capA} * {{WIDTH{1'b0}}, capB};
  assign recomb  = {{WIDTH{1'b0}}, accOut} * {{WIDTH{1'b0}}, capB}
                 + {{WIDTH{1'b0}}, bOut};

  // R1
  mul_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !capDiv |-> {bOut, accOut} == prodChk);

  // R2
  mul_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !capDiv |-> ovOut == (bOut != '0));

  // R3
  div_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && capDiv && capB != '0 |-> recomb == {{WIDTH{1'b0}}, capA} && bOut < capB);

  // R4
  div_ov_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && capDiv && capB != '0 |-> !ovOut);

  // R5
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && capDiv && capB == '0 |-> ovOut && accOut == capA && bOut == '0);

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !carryOut);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyCycles == 8'(STEPS));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(accOut) && $stable(bOut) && $stable(ovOut));
endmodule

bind muldiv_seq muldiv_seq_chk #(.WIDTH(WIDTH), .STEPS(STEPS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opDiv    (opDiv),
  .accIn    (accIn),
  .bIn      (bIn),
  .accOut   (accOut),
  .bOut     (bOut),
  .carryOut (carryOut),
  .ovOut    (ovOut),
  .done     (done),
  .isBusy   (isBusy)
);

// File: tb/sim_muldiv_seq.sv
`timescale 1ns/1ps
module sim_muldiv_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       opDiv = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] bIn = '0;
  logic [7:0] accOut, bOut;
  logic       carryOut, ovOut, done;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  muldiv_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .opDiv(opDiv),
    .accIn(accIn), .bIn(bIn), .accOut(accOut), .bOut(bOut),
    .carryOut(carryOut), .ovOut(ovOut), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {ov, B, A} computed from the requirements
  function automatic logic [16:0] expResult(input logic div, input logic [7:0] a,
                                            input logic [7:0] b);
    logic [15:0] p;
    if (!div) begin
      p = 16'(a) * 16'(b);
      return {p[15:8] != 8'd0, p[15:8], p[7:0]};   // R1 R2
    end else if (b == 8'd0) begin
      return {1'b1, 8'd0, a};                      // R5
    end else begin
      return {1'b0, a % b, a / b};                 // R3 R4
    end
  endfunction

  // called at a negative edge; returns at the negedge of the done cycle
  task automatic runOp(input logic div, input logic [7:0] a, input logic [7:0] b,
                       input bit inject);
    logic [16:0] e;
    e = expResult(div, a, b);
    start = 1'b1; opDiv = div; accIn = a; bIn = b;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (inject && k == 1) begin
        start = 1'b1; opDiv = ~div; accIn = ~a; bIn = b + 8'd3;
      end
      if (inject && k == 2) start = 1'b0;
      check("R7 done low while busy", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    check("R7 done after four cycles", {31'd0, done}, 32'd1);
    check(div ? "R3 quotient" : "R1 product low", {24'd0, accOut}, {24'd0, e[7:0]});
    check(div ? "R3 remainder" : "R1 product high", {24'd0, bOut}, {24'd0, e[15:8]});
    check(div ? "R4 R5 ov" : "R2 ov", {31'd0, ovOut}, {31'd0, e[16]});
    check("R6 carry cleared", {31'd0, carryOut}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset accOut", {24'd0, accOut}, 32'd0);
    check("R9 reset bOut", {24'd0, bOut}, 32'd0);
    check("R9 reset flags/done", {29'd0, carryOut, ovOut, done}, 32'd0);

    // directed multiply corners
    runOp(1'b0, 8'd15, 8'd17, 1'b0);   // 255, R2 clear
    runOp(1'b0, 8'd16, 8'd16, 1'b0);   // 256, R2 set
    runOp(1'b0, 8'd255, 8'd255, 1'b0);
    runOp(1'b0, 8'd0, 8'd200, 1'b0);
    // directed divide corners
    runOp(1'b1, 8'd7, 8'd0, 1'b0);     // R5
    runOp(1'b1, 8'd255, 8'd1, 1'b0);
    runOp(1'b1, 8'd200, 8'd200, 1'b0);
    runOp(1'b1, 8'd5, 8'd9, 1'b0);
    runOp(1'b1, 8'd0, 8'd0, 1'b0);

    // R8: second start inside the busy window is dropped
    runOp(1'b0, 8'd123, 8'd45, 1'b1);
    @(negedge clk);
    check("R8 no extra done", {31'd0, done}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      check("R8 no extra done later", {31'd0, done}, 32'd0);
    end
    // R9: results hold while idle
    check("R9 hold accOut", {24'd0, accOut}, {24'd0, expResult(1'b0, 8'd123, 8'd45) >> 0} & 32'hFF);
    check("R9 hold bOut", {24'd0, bOut}, {24'd0, expResult(1'b0, 8'd123, 8'd45)} >> 8 & 32'hFF);

    // random operations, including back-to-back starts in the done cycle
    for (int n = 0; n < 200; n++) begin
      logic [31:0] r;
      r = $urandom;
      runOp(r[0], r[15:8], (r[3:1] == 3'd0) ? 8'd0 : r[23:16], 1'b0);
    end
    start = 1'b0;
    @(negedge clk);
    check("R7 single pulse", {31'd0, done}, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule